// File: doc/BRIEF.md
# Dual-Read-Port Banked Memory

This block is a 256-word by 8-bit memory with one write port and two read ports. Each read port can fetch any address in any cycle, independent of the other port and of the write port. It is built from four copies of a 128-word by 8-bit storage element. Each storage element has one write port and one synchronous read port, and the project includes a behavioural model of that element.

Two elements placed side by side form one full-depth copy. The most significant address bit picks the element, and the remaining seven bits index a word inside it. A second full-depth copy serves the other read port. Every write goes to the matching element in both copies, so the two copies always hold the same contents.

Reads are synchronous. Read data appears on the clock edge after the read enable is sampled, and it holds while that port's read enable stays low. The element choice is registered together with the read, so the output multiplexer always matches the data the element returns.

Top module: `dual_read_ram`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, both read data outputs are 0.
- R2: When a port's read enable is high at a clock edge, that port's read data after the edge equals the word most recently written to its read address before that edge.
- R3: Address bit 7 selects one of two 128-word halves, and bits 6:0 select the word inside it. A write to address X leaves address X XOR 128 unchanged.
- R4: The two read ports can read different addresses in the same cycle, and each returns the word at its own address.
- R5: A single write is visible to both read ports. Both ports reading the same address in the same cycle return the same word.
- R6: A read of the address being written at the same edge returns the old word. A read at a later edge returns the new word.
- R7: While a port's read enable is low, that port's read data does not change, even when the address it last read is overwritten.
- R8: When write enable is low, the write address and write data have no effect on the stored contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all activity occurs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the read data registers |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Word address of the write |
| wr_data | input | 8 | Word to store |
| rd_a_en | input | 1 | Read enable, port A |
| rd_a_addr | input | 8 | Read address, port A |
| rd_a_data | output | 8 | Read data, port A, one cycle after the enable |
| rd_b_en | input | 1 | Read enable, port B |
| rd_b_addr | input | 8 | Read address, port B |
| rd_b_data | output | 8 | Read data, port B, one cycle after the enable |

## Verification
The hardest case to reach from the ports is a write and two reads that all hit the same address at one edge, because it shows whether both copies give the old word while taking the new one. The stimulus first fills every address with a distinct value. It then issues that combined write and double read in a single cycle, followed by a plain read of the same address. Isolation between the two halves is shown by writing an address and then reading its partner 128 words away on both ports. Output hold is shown by overwriting the last-read address while the enables are low.

// File: rtl/dual_read_ram_pkg.sv
package dual_read_ram_pkg;

  // Which half of the address space a word address falls into.
  function automatic int unsigned half_of(input int unsigned addr, input int unsigned idx_bits);
    return addr >> idx_bits;
  endfunction

  // Word index inside the selected half.
  function automatic int unsigned index_of(input int unsigned addr, input int unsigned idx_bits);
    return addr & ((32'd1 << idx_bits) - 32'd1);
  endfunction

endpackage

// File: rtl/sdp_bank.sv
module sdp_bank #(
  parameter int WIDTH = 8,
  parameter int AW    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [WIDTH-1:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  // Nonblocking update: a read at the write edge sees the old word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/bank_pair.sv
module bank_pair
  import dual_read_ram_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int BANK_AW = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [BANK_AW:0]   wr_addr,
  input  logic [WIDTH-1:0]   wr_data,
  input  logic               rd_en,
  input  logic [BANK_AW:0]   rd_addr,
  output logic [WIDTH-1:0]   rd_data,
  output logic               sel_q
);
  localparam int NBANK = 2;

  logic               wr_half, rd_half;
  logic [BANK_AW-1:0] wr_idx, rd_idx;
  logic [WIDTH-1:0]   bank_q [NBANK];

  always_comb begin
    wr_half = 1'(half_of(32'(wr_addr), BANK_AW));
    rd_half = 1'(half_of(32'(rd_addr), BANK_AW));
    wr_idx  = BANK_AW'(index_of(32'(wr_addr), BANK_AW));
    rd_idx  = BANK_AW'(index_of(32'(rd_addr), BANK_AW));
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    sdp_bank #(.WIDTH(WIDTH), .AW(BANK_AW)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en && (wr_half == 1'(b))),
      .waddr (wr_idx),
      .wdata (wr_data),
      .re    (rd_en && (rd_half == 1'(b))),
      .raddr (rd_idx),
      .rdata (bank_q[b])
    );
  end

  // Half select travels with the synchronous read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sel_q <= 1'b0;
    else if (rd_en) sel_q <= rd_half;
  end

  assign rd_data = bank_q[sel_q];
endmodule

// File: rtl/dual_read_ram.sv
module dual_read_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_a_en,
  input  logic [ADDR_W-1:0] rd_a_addr,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic              rd_b_en,
  input  logic [ADDR_W-1:0] rd_b_addr,
  output logic [DATA_W-1:0] rd_b_data
);
  localparam int NCOPY   = 2;
  localparam int BANK_AW = ADDR_W - 1;

  logic              cp_en   [NCOPY];
  logic [ADDR_W-1:0] cp_addr [NCOPY];
  logic [DATA_W-1:0] cp_data [NCOPY];
  logic [NCOPY-1:0]  bank_sel_q;

  assign cp_en[0]   = rd_a_en;
  assign cp_en[1]   = rd_b_en;
  assign cp_addr[0] = rd_a_addr;
  assign cp_addr[1] = rd_b_addr;

  for (genvar c = 0; c < NCOPY; c++) begin : g_copy
    bank_pair #(.WIDTH(DATA_W), .BANK_AW(BANK_AW)) u_pair (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_en   (cp_en[c]),
      .rd_addr (cp_addr[c]),
      .rd_data (cp_data[c]),
      .sel_q   (bank_sel_q[c])
    );
  end

  assign rd_a_data = cp_data[0];
  assign rd_b_data = cp_data[1];
endmodule

// File: rtl/dual_read_ram_chk.sv
module dual_read_ram_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_a_en,
  input logic [ADDR_W-1:0] rd_a_addr,
  input logic [DATA_W-1:0] rd_a_data,
  input logic              rd_b_en,
  input logic [ADDR_W-1:0] rd_b_addr,
  input logic [DATA_W-1:0] rd_b_data,
  input logic [1:0]        bank_sel_q
);
  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |=> (rd_a_data == '0 && rd_b_data == '0));

  p_hold_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_a_en |=> $stable(rd_a_data));

  p_hold_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_b_en |=> $stable(rd_b_data));

  p_half_sel_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_en |=> bank_sel_q[0] == $past(rd_a_addr[ADDR_W-1]));

  p_half_sel_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b_en |=> bank_sel_q[1] == $past(rd_b_addr[ADDR_W-1]));

  p_copies_agree_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_en && rd_b_en && rd_a_addr == rd_b_addr) |=> (rd_a_data === rd_b_data));
endmodule

bind dual_read_ram dual_read_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_a_en    (rd_a_en),
  .rd_a_addr  (rd_a_addr),
  .rd_a_data  (rd_a_data),
  .rd_b_en    (rd_b_en),
  .rd_b_addr  (rd_b_addr),
  .rd_b_data  (rd_b_data),
  .bank_sel_q (bank_sel_q)
);

// File: tb/test_dual_read_ram.sv
`timescale 1ns/1ps
module test_dual_read_ram;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_a_en = 1'b0, rd_b_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_a_addr = '0, rd_b_addr = '0;
  logic [7:0] rd_a_data, rd_b_data;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] ref_mem [256];
  logic [7:0] ea = '0, eb = '0;
  logic [7:0] qa [$];
  logic [7:0] qb [$];
  string      qt [$];

  always #2 clk = ~clk;

  dual_read_ram i_dual_read_ram (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_a_en(rd_a_en), .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_en(rd_b_en), .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected outputs.
  task automatic step(input bit we, input int wa, input int wd,
                      input bit ae, input int aa, input bit be, input int ba,
                      input string tag);
    @(negedge clk);
    wr_en = we;   wr_addr = 8'(wa);   wr_data = 8'(wd);
    rd_a_en = ae; rd_a_addr = 8'(aa);
    rd_b_en = be; rd_b_addr = 8'(ba);
    if (ae) ea = ref_mem[aa];
    if (be) eb = ref_mem[ba];
    qa.push_back(ea);
    qb.push_back(eb);
    qt.push_back(tag);
    if (we) ref_mem[wa] = 8'(wd);
  endtask

  function automatic int fill_val(input int a);
    return (a * 37 + 11) % 256;
  endfunction

  // Monitor: compares one queued item just after each rising edge.
  initial forever begin
    @(posedge clk);
    #1;
    if (qa.size() > 0) begin
      logic [7:0] xa, xb;
      string t;
      xa = qa.pop_front();
      xb = qb.pop_front();
      t  = qt.pop_front();
      check(rd_a_data, xa, {t, " port A"});
      check(rd_b_data, xb, {t, " port B"});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rd_a_data, 8'h00, "R1 in reset A");
    check(rd_b_data, 8'h00, "R1 in reset B");
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_a_data, 8'h00, "R1 after reset A");
    check(rd_b_data, 8'h00, "R1 after reset B");

    for (int a = 0; a < 256; a++) step(1, a, fill_val(a), 0, 0, 0, 0, "R7 fill idle");

    // R2 / R4: independent addresses on each port
    for (int i = 0; i < 256; i += 17) step(0, 0, 0, 1, i, 1, 255 - i, "R2 R4 split read");
    step(0, 0, 0, 1, 127, 1, 128, "R4 half boundary");
    step(0, 0, 0, 1, 0, 1, 255, "R4 extremes");

    // R3: write one half, partner address untouched
    step(1, 5, 8'hC3, 0, 0, 0, 0, "R3 write low half");
    step(0, 0, 0, 1, 5, 1, 133, "R3 partner untouched");
    step(1, 250, 8'h3C, 0, 0, 0, 0, "R3 write high half");
    step(0, 0, 0, 1, 122, 1, 250, "R3 partner untouched");

    // R5: one write seen by both ports
    step(1, 200, 8'h9E, 0, 0, 0, 0, "R5 broadcast write");
    step(0, 0, 0, 1, 200, 1, 200, "R5 both ports same");

    // R6: read during write returns old, then new
    step(1, 77, 8'hA5, 1, 77, 1, 77, "R6 old on collision");
    step(0, 0, 0, 1, 77, 1, 77, "R6 new after collision");
    step(1, 140, 8'h5A, 1, 140, 0, 0, "R6 old on collision A only");
    step(0, 0, 0, 0, 0, 1, 140, "R6 new on B");

    // R7: held output while last-read word changes
    step(0, 0, 0, 1, 33, 1, 160, "R7 prime");
    step(1, 33, 8'h11, 0, 0, 0, 0, "R7 hold over write");
    step(1, 160, 8'h22, 0, 99, 0, 99, "R7 hold over write");
    step(0, 0, 0, 1, 33, 1, 160, "R7 new after hold");

    // R8: disabled write has no effect
    step(0, 10, 8'hEE, 0, 0, 0, 0, "R8 write disabled");
    step(0, 138, 8'hEE, 0, 0, 0, 0, "R8 write disabled");
    step(0, 0, 0, 1, 10, 1, 138, "R8 contents unchanged");

    step(0, 0, 0, 0, 0, 0, 0, "R7 final idle");
    while (qa.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule